// File: doc/BRIEF.md
# SPI Channel FIFO, Status and Interrupt Unit

This block sits beside the serial shifter of a multi-channel SPI master. Each channel owns a transmit FIFO and a receive FIFO, both eight 32-bit words deep. It also owns a sticky status word, an interrupt-enable word and a threshold word. Software reaches every channel through one register read/write port. Each channel has a 64-byte bank, and the channel is chosen by the address bits above bit 5.

On the engine side, each channel shows its oldest transmit word and accepts pops. It accepts received words, and it takes single-cycle pulses for transfer done, transmit underflow and receive overflow, together with a level busy signal. Threshold conditions are checked on every cycle against the programmed levels. Every status condition sets a sticky bit that software clears by writing one. A single interrupt line is the OR, across all channels, of every sticky bit that is both set and enabled.

Serial shifting, the clock divider and the command logic are outside this block. Register offsets 0x00 to 0x08 of each bank read as zero.

Top module: `spi_fifo_stat_unit`

## Requirements
- R1: Writing offset 0x1C of a bank pushes the write data into that channel's 8-word transmit FIFO. A write to a full transmit FIFO is ignored: the count stays at 8 and the word is never presented to the engine.
- R2: Reading offset 0x20 returns the oldest receive word and removes it. A read of an empty receive FIFO returns zero and leaves the count at zero. An engine push into a full receive FIFO is dropped.
- R3: Offset 0x18 reads the receive occupancy in bits [3:0] and the transmit occupancy in bits [7:4], with all other bits zero.
- R4: Offset 0x0C reads the status word in bits [5:0] with bits [31:6] zero. Bit 0 shows the channel's busy input at the read and is unaffected by writes.
- R5: Status bits 1 to 5 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set condition in the same cycle as a clear wins.
- R6: Offset 0x14 holds the transmit level in bits [3:0] and the receive level in bits [7:4], and resets to 0x80. Status bit 2 sets when transmit occupancy is at or below the transmit level. Status bit 3 sets when receive occupancy is at or above the receive level.
- R7: A done pulse sets status bit 1, an underflow pulse sets bit 4 and an overflow pulse sets bit 5, each on the clock edge that samples the pulse.
- R8: Offset 0x10 holds five enable bits: bit 0 enables status bit 1, bit 1 enables bit 2, bit 2 enables bit 3, bit 3 enables bit 4 and bit 4 enables bit 5. The irq output is high exactly when some channel has a status bit that is both set and enabled.
- R9: Channel n's bank starts at byte address n*0x40. An access to one bank leaves the other channels unchanged. Read data appears on reg_rdata in the cycle after the read strobe and holds until the next read. Unmapped offsets and the write-only offset 0x1C read zero.
- R10: eng_tx_valid of a channel is high while its transmit FIFO is non-empty. eng_tx_data then carries the oldest word, and eng_tx_pop removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address: channel in [7:6], offset in [5:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| eng_busy | input | NUM_CH | Per-channel transfer in progress (level) |
| eng_done | input | NUM_CH | Per-channel transfer done pulse |
| eng_tx_uf | input | NUM_CH | Per-channel transmit underflow pulse |
| eng_rx_of | input | NUM_CH | Per-channel receive overflow pulse |
| eng_tx_pop | input | NUM_CH | Per-channel transmit word taken |
| eng_tx_valid | output | NUM_CH | Per-channel transmit word available |
| eng_tx_data | output | 32*NUM_CH | Per-channel oldest transmit word |
| eng_rx_push | input | NUM_CH | Per-channel received word strobe |
| eng_rx_data | input | 32*NUM_CH | Per-channel received word |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the inputs are known after reset, and that the W1C properties see an event and a clear together only when the set-wins rule applies, which they state in their antecedents. They assume nothing about how the engine paces its pops and pushes. The bench drives at most one register access per cycle. It gives every engine pulse a single-cycle width, and it draws pops, pushes and pulses at random, including pops of an empty FIFO and pushes into a full one. A cycle-accurate model in the bench predicts every read, the irq line and the engine-side head word.

// File: rtl/spi_fsu_pkg.sv
package spi_fsu_pkg;

    localparam int WORD_W      = 32;
    localparam int FIFO_DEPTH  = 8;
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1);
    localparam int BANK_SPAN_W = 6;
    localparam int IEN_W       = 5;

    localparam logic [BANK_SPAN_W-1:0] OFS_STAT = 6'h0C;
    localparam logic [BANK_SPAN_W-1:0] OFS_IEN  = 6'h10;
    localparam logic [BANK_SPAN_W-1:0] OFS_THR  = 6'h14;
    localparam logic [BANK_SPAN_W-1:0] OFS_CNT  = 6'h18;
    localparam logic [BANK_SPAN_W-1:0] OFS_TXD  = 6'h1C;
    localparam logic [BANK_SPAN_W-1:0] OFS_RXD  = 6'h20;

    localparam logic [7:0] THR_RESET = 8'h80;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_IEN,
        SEL_THR,
        SEL_CNT,
        SEL_TXD,
        SEL_RXD
    } reg_sel_e;

    // Sticky status bits 1..5, done in the LSB so the enable bits line up
    typedef struct packed {
        logic rx_of;
        logic tx_uf;
        logic rx_lvl;
        logic tx_lvl;
        logic done;
    } sticky_t;

    typedef struct packed {
        logic [3:0] rx_lvl;
        logic [3:0] tx_lvl;
    } thr_t;

    function automatic reg_sel_e decode_ofs(input logic [BANK_SPAN_W-1:0] ofs);
        case (ofs)
            OFS_STAT: return SEL_STAT;
            OFS_IEN:  return SEL_IEN;
            OFS_THR:  return SEL_THR;
            OFS_CNT:  return SEL_CNT;
            OFS_TXD:  return SEL_TXD;
            OFS_RXD:  return SEL_RXD;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fsu_fifo.sv
module fsu_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 wdata,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             full,
    output logic                             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    p_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_full_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    p_empty_pop_r2: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/fsu_chan.sv
module fsu_chan
    import spi_fsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_tx_uf,
    input  logic              eng_rx_of,
    input  logic              eng_tx_pop,
    output logic              eng_tx_valid,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_data,
    output logic [WORD_W-1:0] rd_val,
    output logic              irq
);
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic              tx_push, rx_pop, stat_wr;
    sticky_t           stk, stk_set, stk_clr;
    thr_t              thr;
    logic [IEN_W-1:0]  ien;

    assign tx_push = wr_en && (sel == SEL_TXD);
    assign rx_pop  = rd_en && (sel == SEL_RXD);
    assign stat_wr = wr_en && (sel == SEL_STAT);

    fsu_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(wdata),
        .pop(eng_tx_pop), .head(eng_tx_data), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    fsu_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_valid = !tx_empty;

    always_comb begin
        stk_set.done   = eng_done;
        stk_set.tx_lvl = (tx_cnt <= thr.tx_lvl);
        stk_set.rx_lvl = (rx_cnt >= thr.rx_lvl);
        stk_set.tx_uf  = eng_tx_uf;
        stk_set.rx_of  = eng_rx_of;
        stk_clr        = stat_wr ? sticky_t'(wdata[5:1]) : sticky_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stk <= '0;
            thr <= thr_t'(THR_RESET);
            ien <= '0;
        end else begin
            stk <= (stk & ~stk_clr) | stk_set;
            if (wr_en && sel == SEL_IEN) ien <= wdata[IEN_W-1:0];
            if (wr_en && sel == SEL_THR) thr <= thr_t'(wdata[7:0]);
        end
    end

    assign irq = |(stk & sticky_t'(ien));

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_STAT: rd_val[5:0] = {stk, eng_busy};
            SEL_IEN:  rd_val[IEN_W-1:0] = ien;
            SEL_THR:  rd_val[7:0] = thr;
            SEL_CNT:  rd_val[7:0] = {tx_cnt, rx_cnt};
            SEL_RXD:  rd_val = rx_empty ? '0 : rx_head;
            default:  rd_val = '0;
        endcase
    end

    p_done_sets_r7: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> stk.done);

    p_w1c_done_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata[1] && !eng_done) |=> !stk.done);

    p_hold_done_r5: assert property (@(posedge clk) disable iff (rst)
        (stk.done && !(stat_wr && wdata[1])) |=> stk.done);

    p_txlvl_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= thr.tx_lvl) |=> stk.tx_lvl);

    p_rxlvl_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt >= thr.rx_lvl) |=> stk.rx_lvl);

endmodule

// File: rtl/spi_fifo_stat_unit.sv
module spi_fifo_stat_unit
    import spi_fsu_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              reg_wr,
    input  logic                                              reg_rd,
    input  logic [BANK_SPAN_W+((NUM_CH>1)?$clog2(NUM_CH):1)-1:0] reg_addr,
    input  logic [WORD_W-1:0]                                 reg_wdata,
    output logic [WORD_W-1:0]                                 reg_rdata,
    input  logic [NUM_CH-1:0]                                 eng_busy,
    input  logic [NUM_CH-1:0]                                 eng_done,
    input  logic [NUM_CH-1:0]                                 eng_tx_uf,
    input  logic [NUM_CH-1:0]                                 eng_rx_of,
    input  logic [NUM_CH-1:0]                                 eng_tx_pop,
    output logic [NUM_CH-1:0]                                 eng_tx_valid,
    output logic [NUM_CH*WORD_W-1:0]                          eng_tx_data,
    input  logic [NUM_CH-1:0]                                 eng_rx_push,
    input  logic [NUM_CH*WORD_W-1:0]                          eng_rx_data,
    output logic                                              irq
);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ADDR_W = BANK_SPAN_W + CH_W;

    logic [CH_W-1:0]   ch_idx;
    logic              ch_ok;
    reg_sel_e          sel;
    logic [WORD_W-1:0] rd_val [NUM_CH];
    logic [NUM_CH-1:0] irq_ch;

    assign ch_idx = reg_addr[ADDR_W-1:BANK_SPAN_W];
    assign ch_ok  = (int'(ch_idx) < NUM_CH);
    assign sel    = decode_ofs(reg_addr[BANK_SPAN_W-1:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = ch_ok && (ch_idx == CH_W'(g));

        fsu_chan u_chan (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (reg_wr && hit),
            .rd_en        (reg_rd && hit),
            .sel          (sel),
            .wdata        (reg_wdata),
            .eng_busy     (eng_busy[g]),
            .eng_done     (eng_done[g]),
            .eng_tx_uf    (eng_tx_uf[g]),
            .eng_rx_of    (eng_rx_of[g]),
            .eng_tx_pop   (eng_tx_pop[g]),
            .eng_tx_valid (eng_tx_valid[g]),
            .eng_tx_data  (eng_tx_data[g*WORD_W +: WORD_W]),
            .eng_rx_push  (eng_rx_push[g]),
            .eng_rx_data  (eng_rx_data[g*WORD_W +: WORD_W]),
            .rd_val       (rd_val[g]),
            .irq          (irq_ch[g])
        );
    end

    assign irq = |irq_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= ch_ok ? rd_val[ch_idx] : '0;
        end
    end

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    p_stat_width_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel == SEL_STAT) |=> (reg_rdata[WORD_W-1:6] == '0));

endmodule

// File: tb/sim_spi_fifo_stat_unit.sv
module sim_spi_fifo_stat_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DEP = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr, reg_rd;
    logic [7:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic [NCH-1:0]    eng_busy, eng_done, eng_tx_uf, eng_rx_of;
    logic [NCH-1:0]    eng_tx_pop, eng_tx_valid, eng_rx_push;
    logic [NCH*32-1:0] eng_tx_data, eng_rx_data;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "";

    // Reference model
    logic [31:0] m_tx [NCH][DEP];
    logic [31:0] m_rx [NCH][DEP];
    int          m_txn [NCH];
    int          m_rxn [NCH];
    logic [4:0]  m_stk [NCH];
    logic [4:0]  m_ien [NCH];
    logic [7:0]  m_thr [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_stat_unit #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_tx_uf(eng_tx_uf),
        .eng_rx_of(eng_rx_of), .eng_tx_pop(eng_tx_pop),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic [5:0] ofs);
        case (ofs)
            6'h0C: return "R4 status read";
            6'h10: return "R8 enable read";
            6'h14: return "R6 threshold read";
            6'h18: return "R3 count read";
            6'h20: return "R2 rx data read";
            default: return "R9 unmapped read";
        endcase
    endfunction

    function automatic logic [31:0] expect_read(int ch, logic [5:0] ofs);
        case (ofs)
            6'h0C: return {26'd0, m_stk[ch], eng_busy[ch]};
            6'h10: return {27'd0, m_ien[ch]};
            6'h14: return {24'd0, m_thr[ch]};
            6'h18: return {24'd0, 4'(m_txn[ch]), 4'(m_rxn[ch])};
            6'h20: return (m_rxn[ch] > 0) ? m_rx[ch][0] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < NCH; c++) r |= |(m_stk[c] & m_ien[c]);
        return r;
    endfunction

    // One clock: predict, advance the model, then compare
    task automatic step();
        int          ch;
        logic [5:0]  ofs;
        logic [31:0] exp_rd;
        ch  = int'(reg_addr[7:6]);
        ofs = reg_addr[5:0];
        for (int c = 0; c < NCH; c++) begin
            chk("R10 tx valid", 32'(eng_tx_valid[c]), 32'(m_txn[c] > 0));
            if (m_txn[c] > 0)
                chk("R10 tx head", eng_tx_data[c*32 +: 32], m_tx[c][0]);
        end
        exp_rd = expect_read(ch, ofs);
        for (int c = 0; c < NCH; c++) begin
            int         ptx, prx;
            logic [4:0] set, clr;
            bit         hit;
            hit = (c == ch);
            ptx = m_txn[c];
            prx = m_rxn[c];
            set = {eng_rx_of[c], eng_tx_uf[c],
                   prx >= int'(m_thr[c][7:4]), ptx <= int'(m_thr[c][3:0]),
                   eng_done[c]};
            clr = (reg_wr && hit && ofs == 6'h0C) ? reg_wdata[5:1] : 5'd0;
            m_stk[c] = (m_stk[c] & ~clr) | set;
            if (reg_wr && hit && ofs == 6'h10) m_ien[c] = reg_wdata[4:0];
            if (reg_wr && hit && ofs == 6'h14) m_thr[c] = reg_wdata[7:0];
            if (eng_tx_pop[c] && ptx > 0) begin
                for (int i = 0; i < DEP - 1; i++) m_tx[c][i] = m_tx[c][i+1];
                m_txn[c]--;
            end
            if (reg_wr && hit && ofs == 6'h1C && ptx < DEP) begin
                m_tx[c][m_txn[c]] = reg_wdata;
                m_txn[c]++;
            end
            if (reg_rd && hit && ofs == 6'h20 && prx > 0) begin
                for (int i = 0; i < DEP - 1; i++) m_rx[c][i] = m_rx[c][i+1];
                m_rxn[c]--;
            end
            if (eng_rx_push[c] && prx < DEP) begin
                m_rx[c][m_rxn[c]] = eng_rx_data[c*32 +: 32];
                m_rxn[c]++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (reg_rd) chk((cur_tag != "") ? cur_tag : tag_of(ofs), reg_rdata, exp_rd);
        chk("R8 irq", 32'(irq), 32'(exp_irq()));
        reg_wr      = 1'b0;
        reg_rd      = 1'b0;
        eng_done    = '0;
        eng_tx_uf   = '0;
        eng_rx_of   = '0;
        eng_tx_pop  = '0;
        eng_rx_push = '0;
    endtask

    task automatic wr(int ch, logic [5:0] ofs, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = {2'(ch), ofs}; reg_wdata = d;
        step();
    endtask

    task automatic rd(int ch, logic [5:0] ofs);
        reg_rd = 1'b1; reg_addr = {2'(ch), ofs};
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        eng_busy = 0; eng_done = 0; eng_tx_uf = 0; eng_rx_of = 0;
        eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
        for (int c = 0; c < NCH; c++) begin
            m_txn[c] = 0; m_rxn[c] = 0; m_stk[c] = 0; m_ien[c] = 0; m_thr[c] = 8'h80;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset irq", 32'(irq), 32'd0);
        chk("R10 reset tx valid", 32'(eng_tx_valid), 32'd0);

        // Reset values
        cur_tag = "R3 reset count"; rd(0, 6'h18);
        cur_tag = "R6 reset threshold"; rd(0, 6'h14);
        cur_tag = "R6 tx level sets at reset"; rd(0, 6'h0C);

        // R1: nine writes into channel 1, ninth dropped
        cur_tag = "";
        for (int i = 0; i < 9; i++) wr(1, 6'h1C, 32'hA000_0000 + i);
        cur_tag = "R1 full count"; rd(1, 6'h18);
        cur_tag = "R9 other bank untouched"; rd(0, 6'h18);
        cur_tag = "R9 write-only reads zero"; rd(1, 6'h1C);
        cur_tag = "";
        for (int i = 0; i < 9; i++) begin eng_tx_pop[1] = 1'b1; step(); end

        // R2: nine engine pushes into channel 2, then ten reads
        for (int i = 0; i < 9; i++) begin
            eng_rx_push[2] = 1'b1;
            eng_rx_data[2*32 +: 32] = 32'hB000_0000 + i;
            step();
        end
        cur_tag = "R2 rx full count"; rd(2, 6'h18);
        cur_tag = "R2 rx drain";
        for (int i = 0; i < 10; i++) rd(2, 6'h20);
        cur_tag = "R2 empty count"; rd(2, 6'h18);

        // R5/R7/R8 on channel 3
        cur_tag = "";
        wr(3, 6'h10, 32'h1);
        eng_done[3] = 1'b1; step();
        cur_tag = "R7 done sets"; rd(3, 6'h0C);
        cur_tag = "R5 write zero keeps"; wr(3, 6'h0C, 32'h0); rd(3, 6'h0C);
        cur_tag = "R5 write one clears"; wr(3, 6'h0C, 32'h2); rd(3, 6'h0C);
        eng_done[3] = 1'b1; reg_wr = 1'b1; reg_addr = {2'd3, 6'h0C}; reg_wdata = 32'h2;
        cur_tag = ""; step();
        cur_tag = "R5 set wins over clear"; rd(3, 6'h0C);
        eng_tx_uf[3] = 1'b1; eng_rx_of[3] = 1'b1; cur_tag = ""; step();
        cur_tag = "R7 error bits"; rd(3, 6'h0C);

        // R4: busy mirror is not clearable
        eng_busy[0] = 1'b1;
        cur_tag = "R4 busy clear ignored"; wr(0, 6'h0C, 32'h3F);
        eng_busy[0] = 1'b1; rd(0, 6'h0C);
        eng_busy[0] = 1'b0;

        // R6: custom levels
        cur_tag = "R6 level write"; wr(1, 6'h14, 32'h0000_0023); rd(1, 6'h14);
        wr(1, 6'h0C, 32'h3E);
        cur_tag = "R6 levels after clear"; rd(1, 6'h0C);

        // Random mix
        cur_tag = "";
        for (int n = 0; n < 4000; n++) begin
            int op, ch;
            op = int'($urandom % 9);
            ch = int'($urandom % NCH);
            for (int c = 0; c < NCH; c++) begin
                eng_tx_pop[c]  = ($urandom % 4) == 0;
                eng_rx_push[c] = ($urandom % 4) == 0;
                eng_rx_data[c*32 +: 32] = $urandom;
                eng_done[c]    = ($urandom % 16) == 0;
                eng_tx_uf[c]   = ($urandom % 32) == 0;
                eng_rx_of[c]   = ($urandom % 32) == 0;
                eng_busy[c]    = ($urandom % 2) == 0;
            end
            case (op)
                0, 1: wr(ch, 6'h1C, $urandom);
                2:    rd(ch, 6'h20);
                3:    rd(ch, 6'h18);
                4:    rd(ch, 6'h0C);
                5:    wr(ch, 6'h0C, $urandom);
                6:    wr(ch, 6'h10, $urandom);
                7:    wr(ch, 6'h14, $urandom);
                default: rd(ch, 6'((($urandom % 3)) * 4 + 16));
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule